// File: doc/BRIEF.md
# Serial Shift and Storage Register

This block turns a serial bit stream into a parallel word. Each rising edge of the shift clock moves a chain of stages along by one position, and a new bit enters at stage 0. A second, independent storage clock copies the whole chain into a holding register. The holding register drives a parallel bus only while the active-low enable is low, so the value the bus shows can be changed in a single step after the serial load is finished.

The last stage also drives a serial output, so several copies can be chained into a longer word. An active-low clear empties the shift chain and the serial output at once, and the holding register keeps its value. The release of that clear is synchronised to the shift clock. A separate active-low clear for the holding register sets its power-up value.

The serial bit and the two clocks form a plain clocked interface with no valid/ready handshake. The shift clock is the data qualifier, and the block never applies back-pressure.

Top module: `shift_store_reg`

## Requirements
- R1: On every rising edge of `shift_clk` while the chain is not held in clear, stage 0 takes `ser_in` and each stage n takes the previous value of stage n-1.
- R2: `ser_out` always equals the highest stage (stage WIDTH-1). After WIDTH shifts it shows the first bit that was shifted in.
- R3: A rising edge of `store_clk` copies all shift stages into the holding register. Stage k appears on `par_pin[k]`, so a byte shifted in MSB-first appears unchanged on the bus.
- R4: While `oe_n` is 0, `par_drive` is 1 and `par_pin` shows the holding register. While `oe_n` is 1, `par_drive` is 0 and `par_pin` is high-impedance. `oe_n` has no effect on `ser_out`.
- R5: `clr_n` low clears every shift stage and `ser_out` at once, with no clock edge needed. The holding register keeps its value.
- R6: After `clr_n` rises, the first SYNC_STAGES (default 2) edges of `shift_clk` leave the chain clear. The next edge shifts normally.
- R7: A `store_clk` edge while `clr_n` is low loads all zeros into the holding register.
- R8: When `shift_clk` and `store_clk` rise on the same edge, the holding register captures the chain as it was before that edge, so storage stays one shift behind.
- R9: `store_clr_n` low clears the holding register at once and leaves the shift stages unchanged.
- R10: When one block's `ser_out` feeds a second block's `ser_in` on shared clocks, the pair acts as one chain of 2×WIDTH stages. The second block then holds the byte that the first block held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift clock; the chain advances on its rising edge |
| store_clk | input | 1 | Storage clock; the holding register loads on its rising edge |
| clr_n | input | 1 | Active-low asynchronous clear of the shift chain; release is synchronised to `shift_clk` |
| store_clr_n | input | 1 | Active-low asynchronous clear of the holding register |
| ser_in | input | 1 | Serial data into stage 0 |
| oe_n | input | 1 | Active-low enable for the parallel bus |
| ser_out | output | 1 | Cascade output from the last stage |
| par_drive | output | 1 | High while the parallel bus is driven |
| par_pin | output | WIDTH | Three-state parallel bus showing the holding register |

## Verification
A shift and a store can fall on the same clock edge. The bench provokes this by gating both clocks from one free-running source so that both rise at the same instant. The result is judged by storing the chain at a known value, then shifting and storing together and comparing the bus against the value from before the edge. A second collision, a store while the chain clear is held, must load zeros and must not reload the older contents. Clear release and the first shifts after it also interact: the bench counts the absorbed edges and reads the result back through a store.

// File: rtl/shift_store_pkg.sv
`timescale 1ns/1ps
package shift_store_pkg;
  localparam int DEF_WIDTH       = 8;
  localparam int DEF_SYNC_STAGES = 2;

  typedef enum logic {
    DRV_OFF = 1'b0,
    DRV_ON  = 1'b1
  } drive_e;
endpackage

// File: rtl/sss_release_sync.sv
`timescale 1ns/1ps
module sss_release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic run_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign run_n = sync_q[STAGES-1];

  // R6
  release_lag_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(run_n) |-> $past(arst_n));
endmodule

// File: rtl/sss_shift_chain.sv
`timescale 1ns/1ps
module sss_shift_chain #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             run_n,
  input  logic             din,
  output logic [WIDTH-1:0] stages,
  output logic             tap
);
  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) stages <= '0;
    else        stages <= {stages[WIDTH-2:0], din};
  end

  assign tap = stages[WIDTH-1];

  // R1
  stage0_take_chk: assert property (@(posedge clk) disable iff (!run_n)
    $past(run_n) |-> (stages[0] == $past(din)));

  // R2
  tap_follow_chk: assert property (@(posedge clk) disable iff (!run_n)
    $past(run_n) |-> (tap == $past(stages[WIDTH-2])));
endmodule

// File: rtl/sss_store_bank.sv
`timescale 1ns/1ps
module sss_store_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= d;
  end

  // R9
  bank_clear_chk: assert property (@(posedge clk)
    !clr_n |-> (q == '0));
endmodule

// File: rtl/sss_pin_drive.sv
`timescale 1ns/1ps
module sss_pin_drive
  import shift_store_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             oe_n,
  input  logic [WIDTH-1:0] d,
  output logic             drive,
  output tri   [WIDTH-1:0] pin
);
  drive_e mode;

  always_comb mode = oe_n ? DRV_OFF : DRV_ON;

  assign drive = (mode == DRV_ON);
  assign pin   = drive ? d : {WIDTH{1'bz}};
endmodule

// File: rtl/shift_store_reg.sv
`timescale 1ns/1ps
module shift_store_reg
  import shift_store_pkg::*;
#(
  parameter int WIDTH       = DEF_WIDTH,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic             shift_clk,
  input  logic             store_clk,
  input  logic             clr_n,
  input  logic             store_clr_n,
  input  logic             ser_in,
  input  logic             oe_n,
  output logic             ser_out,
  output logic             par_drive,
  output tri   [WIDTH-1:0] par_pin
);
  logic             run_n;
  logic [WIDTH-1:0] chain;
  logic [WIDTH-1:0] held;
  logic             tap;

  sss_release_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(shift_clk), .arst_n(clr_n), .run_n(run_n));

  sss_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk(shift_clk), .run_n(run_n), .din(ser_in), .stages(chain), .tap(tap));

  sss_store_bank #(.WIDTH(WIDTH)) u_bank (
    .clk(store_clk), .clr_n(store_clr_n), .d(chain), .q(held));

  sss_pin_drive #(.WIDTH(WIDTH)) u_drive (
    .oe_n(oe_n), .d(held), .drive(par_drive), .pin(par_pin));

  assign ser_out = tap;

  // R5
  clear_empty_chk: assert property (@(posedge shift_clk)
    !clr_n |-> (ser_out == 1'b0));

  // R7
  clear_store_chk: assert property (@(posedge store_clk) disable iff (!store_clr_n)
    !clr_n |-> (chain == '0));
endmodule

// File: tb/sim_shift_store_reg.sv
`timescale 1ns/1ps
module sim_shift_store_reg;
  localparam int W = 8;

  typedef struct packed {
    logic [7:0] data;
    logic       oe_n;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{8'hA5, 1'b0}, '{8'h3C, 1'b1}, '{8'hFF, 1'b0},
    '{8'h00, 1'b0}, '{8'h81, 1'b1}, '{8'h5A, 1'b0}};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic sh_gate = 1'b0, st_gate = 1'b0;
  wire  shift_clk = clk & sh_gate;
  wire  store_clk = clk & st_gate;

  logic clr_n = 1'b0, store_clr_n = 1'b0, oe_n = 1'b0, din = 1'b0;
  wire  ser0, ser1, drv0, drv1;
  wire [W-1:0] pin0, pin1;

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;

  shift_store_reg #(.WIDTH(W)) u0 (
    .shift_clk(shift_clk), .store_clk(store_clk), .clr_n(clr_n),
    .store_clr_n(store_clr_n), .ser_in(din), .oe_n(oe_n),
    .ser_out(ser0), .par_drive(drv0), .par_pin(pin0));

  shift_store_reg #(.WIDTH(W)) u1 (
    .shift_clk(shift_clk), .store_clk(store_clk), .clr_n(clr_n),
    .store_clr_n(store_clr_n), .ser_in(ser0), .oe_n(oe_n),
    .ser_out(ser1), .par_drive(drv1), .par_pin(pin1));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input bit sh, input bit st, input logic d);
    @(negedge clk);
    din = d; sh_gate = sh; st_gate = st;
    @(posedge clk);
    #3;
    sh_gate = 1'b0; st_gate = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL WDOG actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev;
    repeat (3) @(negedge clk);
    #1;
    chk("R5 reset ser_out", {15'd0, ser0}, 16'd0);
    chk("R9 reset storage", {8'd0, pin0}, 16'd0);
    chk("R4 reset drive", {15'd0, drv0}, 16'd1);
    @(negedge clk);
    store_clr_n = 1'b1; clr_n = 1'b1;
    tick(1, 0, 1'b0); tick(1, 0, 1'b0);

    prev = 8'h00;
    for (int v = 0; v < 6; v++) begin
      oe_n = VEC[v].oe_n;
      for (int b = 7; b >= 0; b--) tick(1, 0, VEC[v].data[b]);
      chk("R2 tap after byte", {15'd0, ser0}, {15'd0, VEC[v].data[7]});
      chk("R10 chained tap", {15'd0, ser1}, {15'd0, prev[7]});
      tick(0, 1, 1'b0);
      if (!VEC[v].oe_n) begin
        chk("R3 parallel byte", {8'd0, pin0}, {8'd0, VEC[v].data});
        chk("R10 chained byte", {8'd0, pin1}, {8'd0, prev});
        chk("R4 drive on", {15'd0, drv0}, 16'd1);
      end else begin
        chk("R4 drive off u0", {15'd0, drv0}, 16'd0);
        chk("R4 drive off u1", {15'd0, drv1}, 16'd0);
      end
      prev = VEC[v].data;
    end
    oe_n = 1'b0;

    // R5: asynchronous clear of the chain, storage kept
    for (int b = 0; b < 8; b++) tick(1, 0, 1'b1);
    chk("R1 ones loaded", {15'd0, ser0}, 16'd1);
    @(negedge clk); clr_n = 1'b0; #1;
    chk("R5 async clear ser_out", {15'd0, ser0}, 16'd0);
    chk("R5 storage kept", {8'd0, pin0}, 16'h005A);
    // R7: store during clear loads zeros
    tick(0, 1, 1'b0);
    chk("R7 store during clear", {8'd0, pin0}, 16'd0);
    // R6: release absorbs two shift edges
    @(negedge clk); clr_n = 1'b1;
    tick(1, 0, 1'b1); tick(1, 0, 1'b1);
    tick(0, 1, 1'b0);
    chk("R6 edges absorbed", {8'd0, pin0}, 16'd0);
    tick(1, 0, 1'b1);
    tick(0, 1, 1'b0);
    chk("R6 first live shift", {8'd0, pin0}, 16'h0001);
    // R8: shift and store on the same edge
    tick(1, 1, 1'b1);
    chk("R8 same edge old value", {8'd0, pin0}, 16'h0001);
    tick(0, 1, 1'b0);
    chk("R8 later store", {8'd0, pin0}, 16'h0003);
    // R4: enable has no effect on ser_out
    @(negedge clk); oe_n = 1'b1; #1;
    chk("R4 disabled drive", {15'd0, drv0}, 16'd0);
    chk("R4 ser_out unaffected", {15'd0, ser0}, 16'd0);
    @(negedge clk); oe_n = 1'b0; #1;
    chk("R4 re-enabled bus", {8'd0, pin0}, 16'h0003);
    // R9: storage clear leaves chain
    @(negedge clk); store_clr_n = 1'b0; #1;
    chk("R9 storage cleared", {8'd0, pin0}, 16'd0);
    @(negedge clk); store_clr_n = 1'b1;
    tick(0, 1, 1'b0);
    chk("R9 chain intact", {8'd0, pin0}, 16'h0003);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule